// File: doc/BRIEF.md
# Sector Lock-Bit Manager with Relock

This block changes the lock bit of a single flash sector over a byte-wide command and status bus. It also holds one "intended protection" bit per sector. A request names a sector and says whether to lock it or unlock it. The block issues the command bytes to that sector's base address, polls the device status until the ready bit appears or a cycle budget runs out, and then updates its protection bit for the sector if no error occurred.

The device can only drop lock bits all together, so an unlock request clears every sector in the device. After any unlock, the block therefore walks its protection register in ascending sector order. It issues a lock command to each sector still marked as protected, and each of these relocks gets its own timeout. The block then writes the read-array command and reports completion with a single-cycle done pulse and an error flag. The surrounding controller uses `busy` to decide when it may issue the next request.

Top module: `sector_lock_mgr`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are 0, `prot_map` is all zeros, and neither `fl_we` nor `fl_re` is asserted.
- R2: A request is taken only while `busy` is 0. Its first bus write is 0x50 to the sector base address, which is the sector index shifted left by `BLK_LOG2` bits (index × 0x20000 by default).
- R3: A lock request then writes 0x60 followed by 0x01. An unlock request then writes 0x60 followed by 0xD0. Both go to the same base address.
- R4: After the command, the block reads status with `fl_re` until bit 7 of `fl_rdata` is 1. If `TMO` consecutive reads show bit 7 at 0, the operation ends with an error. Ready on the `TMO`-th read is still a success. For a lock request, `done` appears 5+L cycles after the request cycle, where L is the number of not-ready reads before ready, and 4+`TMO` cycles after it on a timeout.
- R5: A ready status whose value is not exactly 0x80 makes the operation report an error.
- R6: The `prot_map` bit of the requested sector takes the requested value only when the main command had no timeout and no bad status. Otherwise the bit keeps its old value.
- R7: After every unlock request, whether or not it failed, each sector whose `prot_map` bit is 1 gets 0x60 then 0x01 at its base address, in ascending index order. The block then polls that sector with its own timeout, and a ready status value other than 0x80 is not treated as an error.
- R8: A relock timeout sets the error flag, but the walk goes on to the remaining sectors. A relock never changes `prot_map`.
- R9: The last bus action of every request is a write of 0xFF to the requested sector's base. `done` is high for exactly that one cycle, and `done_err` shows the error flag and is 0 whenever `done` is 0.
- R10: A request raised while `busy` is 1 is ignored. It starts no operation and changes neither `prot_map` nor any lock bit in the device.
- R11: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is 0 |
| req_sector | input | SW | Sector index, SW = clog2(NSECT) |
| req_lock | input | 1 | 1 = lock the sector, 0 = unlock |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Error flag, valid with `done` |
| prot_map | output | NSECT | Intended protection, one bit per sector |
| fl_we | output | 1 | Flash bus write strobe |
| fl_re | output | 1 | Flash bus status read strobe |
| fl_addr | output | SW+BLK_LOG2 | Flash byte address |
| fl_wdata | output | 8 | Command byte |
| fl_rdata | input | 8 | Status byte, valid in the same cycle as `fl_re` |

## Verification
The assertions assume two things about the inputs. First, a request is a single strobe whose sector index is below `NSECT`. Second, `fl_rdata` is only meaningful while `fl_re` is high. Nothing is assumed about when the device becomes ready, because the timeout is part of the behaviour under check.

The bench keeps within these limits. It pulses `req_valid` for one cycle at a time with indices in range. It also drives a device model that answers only during reads, with a programmable number of not-ready reads, a good or bad final status, and a per-sector mask that never becomes ready. That mask is how timeouts in the main command and in the relock walk are produced.

// File: rtl/lock_mgr_pkg.sv
package lock_mgr_pkg;

  typedef enum logic [3:0] {
    LK_IDLE,
    LK_CLRSTAT,
    LK_SETUP,
    LK_ARG,
    LK_POLL,
    LK_SCAN,
    LK_RSETUP,
    LK_RARG,
    LK_RPOLL,
    LK_EXIT
  } lk_state_e;

  localparam logic [7:0] OP_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] OP_LOCK_SETUP   = 8'h60;
  localparam logic [7:0] OP_LOCK_ONE     = 8'h01;
  localparam logic [7:0] OP_UNLOCK_ALL   = 8'hD0;
  localparam logic [7:0] OP_READ_ARRAY   = 8'hFF;
  localparam logic [7:0] STATUS_GOOD     = 8'h80;

endpackage

// File: rtl/lock_poll_timer.sv
module lock_poll_timer #(
  parameter int TMO = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic expired
);

  localparam int CW = $clog2(TMO + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = restart | advance;
    cnt_d  = restart ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LAST);

endmodule

// File: rtl/lock_prot_map.sv
module lock_prot_map #(
  parameter int NSECT = 128,
  localparam int SW = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_idx,
  input  logic             wr_val,
  output logic [NSECT-1:0] map_o
);

  for (genvar i = 0; i < NSECT; i++) begin : g_bit
    logic hit;
    assign hit = wr_en & (wr_idx == SW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   map_o[i] <= 1'b0;
      else if (hit) map_o[i] <= wr_val;
    end
  end

endmodule

// File: rtl/sector_lock_mgr.sv
module sector_lock_mgr
  import lock_mgr_pkg::*;
#(
  parameter int NSECT    = 128,
  parameter int BLK_LOG2 = 17,
  parameter int TMO      = 4096,
  localparam int SW      = $clog2(NSECT),
  localparam int ADDR_W  = SW + BLK_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SW-1:0]     req_sector,
  input  logic              req_lock,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  output logic [NSECT-1:0]  prot_map,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  input  logic [7:0]        fl_rdata
);

  localparam int WW = $clog2(NSECT + 1);
  localparam logic [WW-1:0] WALK_END = WW'(NSECT);

  lk_state_e     state_q, state_d;
  logic [SW-1:0] sec_q, sec_d;
  logic          lock_q, lock_d;
  logic          err_q, err_d;
  logic [WW-1:0] walk_q, walk_d;

  logic          tmr_restart, tmr_adv, tmr_last;
  logic          map_we;
  logic          relock_phase;
  logic [SW-1:0] addr_sec;
  logic          st_ready, st_good;

  lock_poll_timer #(.TMO(TMO)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .advance (tmr_adv),
    .expired (tmr_last)
  );

  lock_prot_map #(.NSECT(NSECT)) u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (map_we),
    .wr_idx (sec_q),
    .wr_val (lock_q),
    .map_o  (prot_map)
  );

  assign st_ready     = fl_rdata[7];
  assign st_good      = (fl_rdata == STATUS_GOOD);
  assign relock_phase = (state_q == LK_RSETUP) || (state_q == LK_RARG) ||
                        (state_q == LK_RPOLL);
  assign addr_sec     = relock_phase ? walk_q[SW-1:0] : sec_q;
  assign fl_addr      = {addr_sec, {BLK_LOG2{1'b0}}};
  assign busy         = (state_q != LK_IDLE);

  // next-state and output decode
  always_comb begin
    state_d     = state_q;
    sec_d       = sec_q;
    lock_d      = lock_q;
    err_d       = err_q;
    walk_d      = walk_q;
    fl_we       = 1'b0;
    fl_re       = 1'b0;
    fl_wdata    = OP_READ_ARRAY;
    tmr_restart = 1'b0;
    tmr_adv     = 1'b0;
    map_we      = 1'b0;
    done        = 1'b0;
    done_err    = 1'b0;
    unique case (state_q)
      LK_IDLE: begin
        if (req_valid) begin
          sec_d   = req_sector;
          lock_d  = req_lock;
          err_d   = 1'b0;
          state_d = LK_CLRSTAT;
        end
      end
      LK_CLRSTAT: begin
        fl_we    = 1'b1;
        fl_wdata = OP_CLEAR_STATUS;
        state_d  = LK_SETUP;
      end
      LK_SETUP: begin
        fl_we    = 1'b1;
        fl_wdata = OP_LOCK_SETUP;
        state_d  = LK_ARG;
      end
      LK_ARG: begin
        fl_we       = 1'b1;
        fl_wdata    = lock_q ? OP_LOCK_ONE : OP_UNLOCK_ALL;
        tmr_restart = 1'b1;
        state_d     = LK_POLL;
      end
      LK_POLL: begin
        fl_re = 1'b1;
        if (st_ready || tmr_last) begin
          err_d   = !(st_ready && st_good);
          map_we  = st_ready && st_good;
          walk_d  = '0;
          state_d = lock_q ? LK_EXIT : LK_SCAN;
        end else begin
          tmr_adv = 1'b1;
        end
      end
      LK_SCAN: begin
        if (walk_q == WALK_END)            state_d = LK_EXIT;
        else if (prot_map[walk_q[SW-1:0]]) state_d = LK_RSETUP;
        else                               walk_d  = walk_q + 1'b1;
      end
      LK_RSETUP: begin
        fl_we    = 1'b1;
        fl_wdata = OP_LOCK_SETUP;
        state_d  = LK_RARG;
      end
      LK_RARG: begin
        fl_we       = 1'b1;
        fl_wdata    = OP_LOCK_ONE;
        tmr_restart = 1'b1;
        state_d     = LK_RPOLL;
      end
      LK_RPOLL: begin
        fl_re = 1'b1;
        if (st_ready || tmr_last) begin
          err_d   = err_q | !st_ready;
          walk_d  = walk_q + 1'b1;
          state_d = LK_SCAN;
        end else begin
          tmr_adv = 1'b1;
        end
      end
      LK_EXIT: begin
        fl_we    = 1'b1;
        fl_wdata = OP_READ_ARRAY;
        done     = 1'b1;
        done_err = err_q;
        state_d  = LK_IDLE;
      end
      default: state_d = LK_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      sec_q   <= '0;
      lock_q  <= 1'b0;
      err_q   <= 1'b0;
      walk_q  <= '0;
    end else begin
      state_q <= state_d;
      sec_q   <= sec_d;
      lock_q  <= lock_d;
      err_q   <= err_d;
      walk_q  <= walk_d;
    end
  end

endmodule

// File: rtl/lock_mgr_checks.sv
module lock_mgr_checks #(
  parameter int NSECT = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic             done_err,
  input logic [NSECT-1:0] prot_map,
  input logic             fl_we,
  input logic             fl_re,
  input logic [7:0]       fl_wdata
);

  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_read_array: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fl_we && fl_wdata == 8'hFF));

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  a_r2_first_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (fl_we && fl_wdata == 8'h50));

  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  a_r6_map_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (busy || $stable(prot_map)));

endmodule

bind sector_lock_mgr lock_mgr_checks #(.NSECT(NSECT)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .done_err  (done_err),
  .prot_map  (prot_map),
  .fl_we     (fl_we),
  .fl_re     (fl_re),
  .fl_wdata  (fl_wdata)
);

// File: tb/sector_lock_mgr_test.sv
`timescale 1ns/1ps
module sector_lock_mgr_test;
  localparam int NS  = 8;
  localparam int BLK = 17;
  localparam int TMO = 16;
  localparam int SW  = 3;
  localparam int AW  = SW + BLK;

  logic clk, rst_n, req_valid, req_lock;
  logic [SW-1:0] req_sector;
  logic busy, done, done_err, fl_we, fl_re;
  logic [NS-1:0] prot_map;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  sector_lock_mgr #(.NSECT(NS), .BLK_LOG2(BLK), .TMO(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sector(req_sector),
    .req_lock(req_lock), .busy(busy), .done(done), .done_err(done_err),
    .prot_map(prot_map), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // device model
  logic [NS-1:0] dev = '0;
  logic [NS-1:0] hang_mask = '0;
  int   lat = 0;
  logic bad_st = 1'b0;
  logic pend = 1'b0, pset = 1'b0, pre60 = 1'b0;
  logic [SW-1:0] psec = '0;
  int   wcnt = 0;
  int   nwr = 0, bad_addr = 0;
  logic [7:0] wlog0 = 0, wlog1 = 0, wlog2 = 0, last_wd = 0;
  logic [AW-1:0] first_addr = '0;

  assign fl_rdata = (pend && wcnt == 0 && !hang_mask[psec]) ?
                    (bad_st ? 8'h90 : 8'h80) : 8'h00;

  always @(posedge clk) begin
    if (req_valid && !busy) begin
      nwr <= 0;
      bad_addr <= 0;
    end else if (fl_we) begin
      if (nwr == 0) begin wlog0 <= fl_wdata; first_addr <= fl_addr; end
      if (nwr == 1) wlog1 <= fl_wdata;
      if (nwr == 2) wlog2 <= fl_wdata;
      nwr <= nwr + 1;
      last_wd <= fl_wdata;
      if (fl_addr[BLK-1:0] != '0) bad_addr <= bad_addr + 1;
      pend <= 1'b0;
      if (pre60 && (fl_wdata == 8'h01 || fl_wdata == 8'hD0)) begin
        pend <= 1'b1;
        pset <= (fl_wdata == 8'h01);
        psec <= fl_addr[AW-1:BLK];
        wcnt <= lat;
      end
      pre60 <= (fl_wdata == 8'h60);
    end else if (fl_re && pend) begin
      if (wcnt != 0) wcnt <= wcnt - 1;
      else if (!hang_mask[psec]) begin
        if (pset) dev[psec] <= 1'b1;
        else      dev <= '0;
        pend <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [NS-1:0] prot_e = '0, dev_e = '0;

  task automatic do_op(input int s, input bit lk, input int l, input bit b,
                       input bit poke);
    bit main_fail, err;
    int cnt;
    lat = l; bad_st = b;
    main_fail = hang_mask[s] || (l >= TMO);
    err = main_fail || b;
    if (!main_fail) begin
      if (lk) dev_e[s] = 1'b1; else dev_e = '0;
    end
    if (!err) prot_e[s] = lk;
    if (!lk) begin
      for (int i = 0; i < NS; i++)
        if (prot_e[i]) begin
          if (hang_mask[i] || l >= TMO) err = 1'b1;
          else dev_e[i] = 1'b1;
        end
    end
    req_sector = SW'(s); req_lock = lk; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    cnt = 1;
    while (!done && cnt < 3000) begin
      if (poke && cnt == 2) begin
        req_sector = SW'((s + 3) % NS); req_lock = 1'b1; req_valid = 1'b1;
      end
      @(negedge clk); cnt++;
      req_valid = 1'b0;
    end
    if (!done) begin
      chk(1'b0, "R9", "watchdog: no done", cnt, 0);
      return;
    end
    chk(done_err == err, lk ? "R6" : "R8", "done_err", done_err, err);
    chk(prot_map == prot_e, "R6", "prot_map", prot_map, prot_e);
    chk(first_addr == AW'(s) << BLK && wlog0 == 8'h50, "R2", "first write",
        wlog0, 8'h50);
    chk(wlog1 == 8'h60 && wlog2 == (lk ? 8'h01 : 8'hD0), "R3", "command",
        wlog2, lk ? 8'h01 : 8'hD0);
    chk(fl_we && fl_wdata == 8'hFF && fl_addr == AW'(s) << BLK, "R9",
        "final write", fl_wdata, 8'hFF);
    chk(bad_addr == 0, "R2", "unaligned writes", bad_addr, 0);
    if (lk) chk(cnt == (main_fail ? 4 + TMO : 5 + l), "R4", "latency",
                cnt, main_fail ? 4 + TMO : 5 + l);
    @(negedge clk);
    chk(dev == dev_e, lk ? "R4" : "R7", "device locks", dev, dev_e);
    if (poke) begin
      @(negedge clk); @(negedge clk);
      chk(!busy, "R10", "busy after ignored request", busy, 0);
      chk(dev == dev_e && prot_map == prot_e, "R10", "state after ignored",
          prot_map, prot_e);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_lock = 1'b0; req_sector = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && prot_map == '0 && !fl_we && !fl_re, "R1",
        "reset state", {busy, done, fl_we, fl_re}, 0);
    chk(!fl_we && !fl_re, "R11", "no strobes at reset", {fl_we, fl_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // lock every sector, varying ready latency
    for (int s = 0; s < NS; s++) do_op(s, 1'b1, s % 4, 1'b0, 1'b0);
    do_op(2, 1'b0, 1, 1'b0, 1'b0);          // unlock with relock walk (R7)
    do_op(5, 1'b0, 0, 1'b1, 1'b0);          // bad status (R5)
    hang_mask = 8'h20;
    do_op(5, 1'b0, 0, 1'b0, 1'b0);          // main timeout, relock 5 fails (R4, R8)
    hang_mask = 8'h01;
    do_op(4, 1'b0, 2, 1'b0, 1'b0);          // relock of 0 times out, walk goes on (R8)
    hang_mask = '0;
    do_op(2, 1'b1, TMO - 1, 1'b0, 1'b0);    // ready on last read (R4)
    do_op(4, 1'b1, TMO, 1'b0, 1'b0);        // timeout (R4)
    do_op(4, 1'b1, 0, 1'b1, 1'b0);          // bad status on lock (R5)
    do_op(1, 1'b0, 0, 1'b0, 1'b1);          // request while busy (R10)
    for (int s = 0; s < NS; s++) do_op(s, 1'b0, s % 3, 1'b0, 1'b0);
    do_op(6, 1'b0, 0, 1'b0, 1'b0);          // empty map: no relock
    chk(prot_map == '0, "R7", "map empty", prot_map, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule